// File: doc/BRIEF.md
# Pipelined AES-128 encryptor

This block turns 128-bit plaintext blocks into ciphertext under a 128-bit key using the AES-128 cipher. The ten rounds are built as separate hardware. Every round step has its own register stage, so the core takes a new block on every clock and returns each result after a fixed delay. Each block carries its own key. The round keys are expanded in a parallel register chain that moves in step with the data. Blocks that follow each other may therefore use unrelated keys, and nothing has to be drained between them.

The byte substitution reads a constant 256-entry table. The table is computed when the design is elaborated, from the field inverse and the affine map. A single valid bit per stage follows each block through the pipe. An asynchronous active-low reset clears only these valid bits. The data and key registers carry no reset, because their contents are meaningless while the matching valid bit is low.

Top module: `aes128_enc_pipe`

## Requirements
- R1: For every accepted block, `ct_o` is the AES-128 encryption of `pt_i` under `key_i`. Byte 0 of every 128-bit value sits in bits [127:120]. For example, key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff give 69c4e0d86a7b0430d8cdb78070b4c55a.
- R2: A block is accepted on a rising edge at which `valid_i` is 1. `valid_o` is 1 and `ct_o` holds its ciphertext after the 41st rising edge, counting the accepting edge as the first. Neither appears earlier.
- R3: A new block may be accepted on every edge. Blocks accepted on consecutive edges leave on consecutive cycles, in the order they entered.
- R4: Each block is encrypted under the key presented with it, even when the key changes on every cycle.
- R5: While `rst_ni` is 0, `valid_o` is 0. After release, `valid_o` stays 0 until a block accepted after the release reaches the output.
- R6: An edge with `valid_i` at 0 yields a cycle with `valid_o` at 0, 41 edges later. The `pt_i` and `key_i` values present on such edges do not change the ciphertext of any accepted block.
- R7: Blocks still in flight when reset is asserted are discarded. None of them ever raises `valid_o`, and the pipe works normally once the reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low, clears the valid pipe |
| valid_i | input | 1 | Plaintext and key present this cycle |
| pt_i | input | 128 | Plaintext block, byte 0 in bits [127:120] |
| key_i | input | 128 | Cipher key for this block, byte 0 in bits [127:120] |
| valid_o | output | 1 | `ct_o` holds a finished block |
| ct_o | output | 128 | Ciphertext block, byte 0 in bits [127:120] |

## Verification
A wrong table entry, a wrong mixing coefficient or a wrong round constant scrambles the whole ciphertext of every block that touches it. Such a fault shows on `ct_o` at the 41st edge after that block entered. A key stage that is off by one register gives no sign while the key is held constant. It only shows when neighbouring blocks carry different keys, so those blocks are streamed back to back. A valid pipe that is too short, too long or not cleared shows at once as `valid_o` rising a cycle early or late, or rising after a reset that should have discarded the blocks in flight.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;

  localparam int unsigned BLOCK_W     = 128;
  localparam int unsigned NB_BYTES    = BLOCK_W / 8;
  localparam int unsigned N_COLS      = 4;
  localparam int unsigned N_ROUNDS    = 10;
  localparam int unsigned STAGES_MID  = 4;
  localparam int unsigned STAGES_LAST = 3;
  // input register + initial key add + full rounds + last round
  localparam int unsigned LATENCY     = 2 + (N_ROUNDS - 1) * STAGES_MID + STAGES_LAST;

  typedef logic [BLOCK_W-1:0] blk_t;
  typedef logic [255:0][7:0]  sbox_lut_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = 8'h00;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = xtime(x);
    end
    return acc;
  endfunction

  // a^254, which is the inverse for a != 0 and 0 for a == 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] r;
    sq = a;
    r  = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox_calc(input logic [7:0] a);
    logic [7:0] b;
    b = gf_inv(a);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  function automatic sbox_lut_t build_sbox();
    sbox_lut_t t;
    for (int i = 0; i < 256; i++) t[i] = sbox_calc(8'(i));
    return t;
  endfunction

  localparam sbox_lut_t SBOX = build_sbox();

  function automatic logic [7:0] rcon(input int unsigned rnd);
    logic [7:0] c;
    c = 8'h01;
    for (int unsigned i = 1; i < rnd; i++) c = xtime(c);
    return c;
  endfunction

  // byte (row r, column c) sits at index 4c+r
  function automatic blk_t shift_rows(input blk_t s);
    blk_t o;
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        o[BLOCK_W-1-8*(4*c+r) -: 8] = s[BLOCK_W-1-8*(4*((c+r)%4)+r) -: 8];
      end
    end
    return o;
  endfunction

  function automatic logic [31:0] mix_col(input logic [31:0] w);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = w;
    return {xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
            xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)};
  endfunction

  function automatic blk_t mix_columns(input blk_t s);
    blk_t o;
    for (int c = 0; c < N_COLS; c++) begin
      o[BLOCK_W-1-32*c -: 32] = mix_col(s[BLOCK_W-1-32*c -: 32]);
    end
    return o;
  endfunction

endpackage

// File: rtl/aes_sub_bytes.sv
module aes_sub_bytes
  import aes_enc_pkg::*;
#(
  parameter int unsigned NBYTES = 16
) (
  input  logic [8*NBYTES-1:0] din_i,
  output logic [8*NBYTES-1:0] dout_o
);

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign dout_o[8*g +: 8] = SBOX[din_i[8*g +: 8]];
  end

endmodule

// File: rtl/aes_key_step.sv
module aes_key_step
  import aes_enc_pkg::*;
#(
  parameter int unsigned ROUND = 1
) (
  input  blk_t key_i,
  output blk_t key_o
);

  localparam logic [7:0] RC = rcon(ROUND);

  logic [31:0] w0, w1, w2, w3;
  logic [31:0] rot_w, sub_w;
  logic [31:0] n0, n1, n2, n3;

  assign {w0, w1, w2, w3} = key_i;
  assign rot_w = {w3[23:0], w3[31:24]};

  aes_sub_bytes #(.NBYTES(4)) u_sub (
    .din_i  (rot_w),
    .dout_o (sub_w)
  );

  assign n0 = w0 ^ sub_w ^ {RC, 24'h000000};
  assign n1 = w1 ^ n0;
  assign n2 = w2 ^ n1;
  assign n3 = w3 ^ n2;
  assign key_o = {n0, n1, n2, n3};

endmodule

// File: rtl/aes_key_pipe.sv
module aes_key_pipe
  import aes_enc_pkg::*;
(
  input  logic clk_i,
  input  blk_t key_i,
  output blk_t rk_o [N_ROUNDS]
);

  // kin[r] is aligned with the state entering round r+1
  blk_t kin [N_ROUNDS];

  assign kin[0] = key_i;

  for (genvar r = 0; r < N_ROUNDS; r++) begin : g_rk
    blk_t nxt_d, k_sb_q, k_sr_q;

    aes_key_step #(.ROUND(r + 1)) u_step (
      .key_i (kin[r]),
      .key_o (nxt_d)
    );

    always_ff @(posedge clk_i) begin
      k_sb_q <= nxt_d;
      k_sr_q <= k_sb_q;
    end

    if (r == N_ROUNDS - 1) begin : g_last
      assign rk_o[r] = k_sr_q;
    end else begin : g_mid
      blk_t k_mc_q, k_ark_q;
      always_ff @(posedge clk_i) begin
        k_mc_q  <= k_sr_q;
        k_ark_q <= k_mc_q;
      end
      assign rk_o[r]    = k_mc_q;
      assign kin[r + 1] = k_ark_q;
    end
  end

endmodule

// File: rtl/aes_round.sv
module aes_round
  import aes_enc_pkg::*;
#(
  parameter bit FINAL = 1'b0
) (
  input  logic clk_i,
  input  blk_t state_i,
  input  blk_t rk_i,
  output blk_t state_o
);

  blk_t sb_d, sb_q, sr_q, ark_q;

  aes_sub_bytes #(.NBYTES(NB_BYTES)) u_sb (
    .din_i  (state_i),
    .dout_o (sb_d)
  );

  always_ff @(posedge clk_i) begin
    sb_q <= sb_d;
    sr_q <= shift_rows(sb_q);
  end

  if (FINAL) begin : g_last
    always_ff @(posedge clk_i) ark_q <= sr_q ^ rk_i;
  end else begin : g_mid
    blk_t mc_q;
    always_ff @(posedge clk_i) begin
      mc_q  <= mix_columns(sr_q);
      ark_q <= mc_q ^ rk_i;
    end
  end

  assign state_o = ark_q;

endmodule

// File: rtl/aes128_enc_pipe.sv
module aes128_enc_pipe
  import aes_enc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [BLOCK_W-1:0] pt_i,
  input  logic [BLOCK_W-1:0] key_i,
  output logic               valid_o,
  output logic [BLOCK_W-1:0] ct_o
);

  blk_t pt_q, key_q, s0_q, k0_q;
  blk_t st [N_ROUNDS+1];
  blk_t rk [N_ROUNDS];
  logic [LATENCY-1:0] vld_q;

  // data path carries no reset; validity lives in vld_q only
  always_ff @(posedge clk_i) begin
    pt_q  <= pt_i;
    key_q <= key_i;
    s0_q  <= pt_q ^ key_q;
    k0_q  <= key_q;
  end

  assign st[0] = s0_q;

  aes_key_pipe u_keys (
    .clk_i (clk_i),
    .key_i (k0_q),
    .rk_o  (rk)
  );

  for (genvar r = 0; r < N_ROUNDS; r++) begin : g_rnd
    aes_round #(.FINAL(r == N_ROUNDS - 1)) u_rnd (
      .clk_i   (clk_i),
      .state_i (st[r]),
      .rk_i    (rk[r]),
      .state_o (st[r + 1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[LATENCY-2:0], valid_i};
  end

  assign valid_o = vld_q[LATENCY-1];
  assign ct_o    = st[N_ROUNDS];

endmodule

// File: rtl/aes_enc_chk.sv
module aes_enc_chk #(
  parameter int unsigned LAT = 41
) (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic valid_o
);

  localparam int unsigned CW = $clog2(LAT + 2);

  logic [CW-1:0]  age_q;
  logic [CW-1:0]  inflight_q;
  logic [LAT-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q      <= '0;
      inflight_q <= '0;
      hist_q     <= '0;
    end else begin
      if (age_q != CW'(LAT)) age_q <= age_q + 1'b1;
      inflight_q <= inflight_q + CW'(valid_i) - CW'(valid_o);
      hist_q     <= {hist_q[LAT-2:0], valid_i};
    end
  end

  // R5 R7
  early_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q < CW'(LAT)) |-> !valid_o);

  // R2
  vld_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == hist_q[LAT-1]);

  // R3
  inflight_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= CW'(LAT));

  // R6
  no_phantom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (inflight_q != '0));

endmodule

bind aes128_enc_pipe aes_enc_chk #(.LAT(aes_enc_pkg::LATENCY)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .valid_o (valid_o)
);

// File: tb/sim_aes128_enc_pipe.sv
module sim_aes128_enc_pipe;

  localparam int LAT = 41;

  logic         clk_i   = 1'b0;
  logic         rst_ni  = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] pt_i    = '0;
  logic [127:0] key_i   = '0;
  logic         valid_o;
  logic [127:0] ct_o;

  int n_chk = 0;
  int n_err = 0;

  logic [127:0] v_key [4];
  logic [127:0] v_pt  [4];
  logic [127:0] v_ct  [4];

  aes128_enc_pipe u0 (.*);

  always #5 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // slot j drives at negedge j; its result is visible at negedge j+LAT
  task automatic run_pattern(input string req, input int n,
                             input logic [63:0] vmask, input int base);
    for (int c = 0; c < n + LAT; c++) begin
      @(negedge clk_i);
      if (c >= LAT) begin
        int j;
        j = c - LAT;
        check(valid_o === vmask[j], {req, " valid_o"}, 128'(valid_o), 128'(vmask[j]));
        if (vmask[j])
          check(ct_o === v_ct[(base + j) % 4], {req, " ct_o"}, ct_o, v_ct[(base + j) % 4]);
      end else begin
        check(valid_o === 1'b0, "R2 no early valid_o", 128'(valid_o), 128'(0));
      end
      if (c < n && vmask[c]) begin
        valid_i = 1'b1;
        pt_i    = v_pt[(base + c) % 4];
        key_i   = v_key[(base + c) % 4];
      end else begin
        valid_i = 1'b0;
        pt_i    = {4{32'hdeadbeef}} ^ 128'(c);
        key_i   = {4{32'h5a5aa5a5}} ^ 128'(c * 7);
      end
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk_i);
    check(valid_o === 1'b0, "R5 valid_o in reset", 128'(valid_o), 128'(0));
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_single_block();
    run_pattern("R1 R2 single", 1, 64'h1, 0);
  endtask

  task automatic t_zero_key();
    run_pattern("R1 zero key", 1, 64'h1, 1);
  endtask

  task automatic t_key_switch();
    run_pattern("R3 R4 key switch", 4, 64'hf, 0);
  endtask

  task automatic t_bubbles();
    run_pattern("R6 bubbles", 8, 64'b1011_0101, 1);
  endtask

  task automatic t_full_stream();
    run_pattern("R3 full stream", 60, 64'hffff_ffff_ffff_ffff, 2);
  endtask

  task automatic t_flush();
    for (int c = 0; c < 6; c++) begin
      @(negedge clk_i);
      valid_i = 1'b1;
      pt_i    = v_pt[c % 4];
      key_i   = v_key[c % 4];
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (10) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(valid_o === 1'b0, "R5 valid_o in reset", 128'(valid_o), 128'(0));
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int c = 0; c < LAT + 5; c++) begin
      @(negedge clk_i);
      check(valid_o === 1'b0, "R7 flushed block", 128'(valid_o), 128'(0));
    end
    run_pattern("R7 after flush", 2, 64'h3, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    v_key[0] = 128'h000102030405060708090a0b0c0d0e0f;
    v_pt[0]  = 128'h00112233445566778899aabbccddeeff;
    v_ct[0]  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    v_key[1] = 128'h0;
    v_pt[1]  = 128'h0;
    v_ct[1]  = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;
    v_key[2] = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    v_pt[2]  = 128'h3243f6a8885a308d313198a2e0370734;
    v_ct[2]  = 128'h3925841d02dc09fbdc118597196a0b32;
    v_key[3] = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    v_pt[3]  = 128'h6bc1bee22e409f96e93d7e117393172a;
    v_ct[3]  = 128'h3ad77bb40d7a3660a89ecaf32466ef97;

    t_reset_state();
    t_single_block();
    t_zero_key();
    t_key_switch();
    t_bubbles();
    t_full_stream();
    t_flush();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule